// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds four 16-bit general registers used as accumulator (index 0), base (index 1), counter (index 2) and data register (index 3). Each register can be reached as a whole word or as either of its two byte halves. The byte halves are views of the word, not separate storage. A byte write merges into the word, and the half it does not address keeps its value.

Two combinational read ports and one clocked write port each carry a 3-bit selector and a size bit. Two side paths run next to the write port. The first decrements the counter by one for repeat and loop sequences and reports when that decrement reaches zero. The second loads a 32-bit product, with the high word going to the data register and the low word to the accumulator in the same clock edge. Arithmetic, decode and memory traffic live elsewhere.

Top module: `gpr_file`

## Requirements
- R1: After an active-low reset every register reads 0x0000 on both read ports.
- R2: With the size bit low (word mode), a port addresses register sel[1:0] as a full 16-bit value. sel[2] is ignored in word mode. A word write loads all 16 bits on the next rising clock edge.
- R3: With the size bit high (byte mode), selectors 0–3 address bits 7..0 and selectors 4–7 address bits 15..8 of register sel[1:0]. A byte read returns the half on data bits 7..0 with bits 15..8 zero.
- R4: A byte write takes wr_data[7:0], replaces only the addressed half and leaves the other half of that register unchanged.
- R5: The two read ports are independent, and each returns its own selection in the same cycle.
- R6: A read of a register that is being written in the same cycle returns the old value. The new value appears after the clock edge.
- R7: With dec_en high, the counter (register 2) becomes its value minus one on the next edge, wrapping from 0x0000 to 0xFFFF.
- R8: cnt_zero is high exactly when dec_en is high and the counter currently holds 0x0001, so that the decrement result is zero.
- R9: A write-port access of any size that targets the counter in the same cycle as dec_en wins. The counter takes only the write-port data, and no decrement is applied.
- R10: With mul_en high, the data register (3) takes mul_prod[31:16] and the accumulator (0) takes mul_prod[15:0] on the same edge.
- R11: If the write port targets the accumulator or the data register while mul_en is high, the write port wins for that register. The other register still takes its product half.
- R12: Decrement and product load in the same cycle both take effect, because they touch different registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_sel | input | 3 | Read port 0 selector |
| rd0_byte | input | 1 | Read port 0 size: 1 = byte, 0 = word |
| rd0_data | output | 16 | Read port 0 data |
| rd1_sel | input | 3 | Read port 1 selector |
| rd1_byte | input | 1 | Read port 1 size |
| rd1_data | output | 16 | Read port 1 data |
| wr_en | input | 1 | Write port enable |
| wr_sel | input | 3 | Write port selector |
| wr_byte | input | 1 | Write port size |
| wr_data | input | 16 | Write data (bits 7..0 used in byte mode) |
| dec_en | input | 1 | Decrement counter register |
| cnt_zero | output | 1 | Decrement result is zero |
| mul_en | input | 1 | Load 32-bit product |
| mul_prod | input | 32 | Product: high word to data reg, low word to accumulator |

## Verification
The sharpest collision is the write port and the counter decrement landing on register 2 in the same cycle. The bench provokes it with a word write and also with a high-byte write issued alongside dec_en. It judges the outcome by reading the counter word afterwards, which must show only the written data with no trace of a decrement in either half. A second overlap, between the product load and a write port aimed at the accumulator, is provoked the same way. It is judged by checking that the accumulator holds the written data while the data register still takes the high product word.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int GPR_W   = 16;
    localparam int GPR_N   = 4;
    localparam int IDX_ACC = 0;
    localparam int IDX_CNT = 2;
    localparam int IDX_DAT = 3;
endpackage

// File: rtl/gpr_sel_decode.sv
module gpr_sel_decode #(
    parameter int N  = gpr_pkg::GPR_N,
    localparam int IW = $clog2(N),
    localparam int SW = IW + 1
) (
    input  logic [SW-1:0] sel,
    input  logic          byte_mode,
    output logic [IW-1:0] idx,
    output logic          hi_half
);
    assign idx     = sel[IW-1:0];
    assign hi_half = byte_mode & sel[IW];
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
    parameter int N  = gpr_pkg::GPR_N,
    parameter int DW = gpr_pkg::GPR_W,
    localparam int IW = $clog2(N),
    localparam int SW = IW + 1,
    localparam int HW = DW / 2
) (
    input  logic [N-1:0][DW-1:0] regs,
    input  logic [SW-1:0]        sel,
    input  logic                 byte_mode,
    output logic [DW-1:0]        data
);
    logic [IW-1:0] idx;
    logic          hi_half;
    logic [DW-1:0] word;

    gpr_sel_decode #(.N(N)) i_dec (
        .sel(sel), .byte_mode(byte_mode), .idx(idx), .hi_half(hi_half)
    );

    assign word = regs[idx];

    always_comb begin
        if (!byte_mode)
            data = word;
        else if (hi_half)
            data = {{HW{1'b0}}, word[DW-1:HW]};
        else
            data = {{HW{1'b0}}, word[HW-1:0]};
    end
endmodule

// File: rtl/gpr_cell.sv
module gpr_cell #(
    parameter int DW = gpr_pkg::GPR_W,
    localparam int HW = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_hit,
    input  logic [1:0]    port_mask,
    input  logic [DW-1:0] port_data,
    input  logic          alt_en,
    input  logic [DW-1:0] alt_data,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (port_hit) begin
            if (port_mask[0]) q[HW-1:0]  <= port_data[HW-1:0];
            if (port_mask[1]) q[DW-1:HW] <= port_data[DW-1:HW];
        end else if (alt_en) begin
            q <= alt_data;
        end
    end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
    parameter int N       = gpr_pkg::GPR_N,
    parameter int DW      = gpr_pkg::GPR_W,
    parameter int ACC_IDX = gpr_pkg::IDX_ACC,
    parameter int CNT_IDX = gpr_pkg::IDX_CNT,
    parameter int DAT_IDX = gpr_pkg::IDX_DAT,
    localparam int IW = $clog2(N),
    localparam int SW = IW + 1,
    localparam int HW = DW / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   rd0_sel,
    input  logic            rd0_byte,
    output logic [DW-1:0]   rd0_data,
    input  logic [SW-1:0]   rd1_sel,
    input  logic            rd1_byte,
    output logic [DW-1:0]   rd1_data,
    input  logic            wr_en,
    input  logic [SW-1:0]   wr_sel,
    input  logic            wr_byte,
    input  logic [DW-1:0]   wr_data,
    input  logic            dec_en,
    output logic            cnt_zero,
    input  logic            mul_en,
    input  logic [2*DW-1:0] mul_prod
);
    logic [N-1:0][DW-1:0] regs_q;
    logic [IW-1:0]        wr_idx;
    logic                 wr_hi;
    logic [1:0]           wr_mask;
    logic [DW-1:0]        wr_aligned;

    gpr_sel_decode #(.N(N)) i_wdec (
        .sel(wr_sel), .byte_mode(wr_byte), .idx(wr_idx), .hi_half(wr_hi)
    );

    always_comb begin
        if (!wr_byte) begin
            wr_mask    = 2'b11;
            wr_aligned = wr_data;
        end else begin
            wr_mask    = wr_hi ? 2'b10 : 2'b01;
            wr_aligned = {wr_data[HW-1:0], wr_data[HW-1:0]};
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic          alt_en;
        logic [DW-1:0] alt_data;

        if (g == CNT_IDX) begin : g_cnt
            assign alt_en   = dec_en;
            assign alt_data = regs_q[g] - DW'(1);
        end else if (g == DAT_IDX) begin : g_dat
            assign alt_en   = mul_en;
            assign alt_data = mul_prod[2*DW-1:DW];
        end else if (g == ACC_IDX) begin : g_acc
            assign alt_en   = mul_en;
            assign alt_data = mul_prod[DW-1:0];
        end else begin : g_plain
            assign alt_en   = 1'b0;
            assign alt_data = '0;
        end

        gpr_cell #(.DW(DW)) i_cell (
            .clk(clk), .rst_n(rst_n),
            .port_hit(wr_en && (wr_idx == IW'(g))),
            .port_mask(wr_mask), .port_data(wr_aligned),
            .alt_en(alt_en), .alt_data(alt_data),
            .q(regs_q[g])
        );
    end

    assign cnt_zero = dec_en && (regs_q[CNT_IDX] == DW'(1));

    gpr_read_port #(.N(N), .DW(DW)) i_rp0 (
        .regs(regs_q), .sel(rd0_sel), .byte_mode(rd0_byte), .data(rd0_data)
    );
    gpr_read_port #(.N(N), .DW(DW)) i_rp1 (
        .regs(regs_q), .sel(rd1_sel), .byte_mode(rd1_byte), .data(rd1_data)
    );
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
    parameter int N       = 4,
    parameter int DW      = 16,
    parameter int ACC_IDX = 0,
    parameter int CNT_IDX = 2,
    parameter int DAT_IDX = 3,
    localparam int IW = $clog2(N),
    localparam int SW = IW + 1,
    localparam int HW = DW / 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [SW-1:0]        wr_sel,
    input logic                 wr_byte,
    input logic [DW-1:0]        wr_data,
    input logic                 dec_en,
    input logic                 cnt_zero,
    input logic                 mul_en,
    input logic [2*DW-1:0]      mul_prod,
    input logic [N-1:0][DW-1:0] regs_q
);
    // R4
    hi_write_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte && wr_sel[IW]) |=>
        regs_q[$past(wr_sel[IW-1:0])][HW-1:0] == $past(regs_q[wr_sel[IW-1:0]][HW-1:0]));

    // R4
    low_write_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte && !wr_sel[IW]) |=>
        regs_q[$past(wr_sel[IW-1:0])][DW-1:HW] == $past(regs_q[wr_sel[IW-1:0]][DW-1:HW]));

    // R7
    counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !wr_en) |=> regs_q[CNT_IDX] == $past(regs_q[CNT_IDX]) - DW'(1));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_zero && !wr_en) |=> regs_q[CNT_IDX] == '0);

    // R9
    port_beats_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && wr_en && !wr_byte && wr_sel[IW-1:0] == IW'(CNT_IDX)) |=>
        regs_q[CNT_IDX] == $past(wr_data));

    // R10
    product_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_en && !wr_en) |=>
        (regs_q[DAT_IDX] == $past(mul_prod[2*DW-1:DW])) &&
        (regs_q[ACC_IDX] == $past(mul_prod[DW-1:0])));
endmodule

bind gpr_file gpr_file_chk #(
    .N(N), .DW(DW), .ACC_IDX(ACC_IDX), .CNT_IDX(CNT_IDX), .DAT_IDX(DAT_IDX)
) i_gpr_file_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_byte(wr_byte), .wr_data(wr_data), .dec_en(dec_en),
    .cnt_zero(cnt_zero), .mul_en(mul_en), .mul_prod(mul_prod),
    .regs_q(regs_q)
);

// File: tb/test_gpr_file.sv
module test_gpr_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd0_sel = '0, rd1_sel = '0, wr_sel = '0;
    logic        rd0_byte = 1'b0, rd1_byte = 1'b0, wr_byte = 1'b0;
    logic [15:0] rd0_data, rd1_data, wr_data = '0;
    logic        wr_en = 1'b0, dec_en = 1'b0, mul_en = 1'b0, cnt_zero;
    logic [31:0] mul_prod = '0;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpr_file i_gpr_file (
        .clk(clk), .rst_n(rst_n),
        .rd0_sel(rd0_sel), .rd0_byte(rd0_byte), .rd0_data(rd0_data),
        .rd1_sel(rd1_sel), .rd1_byte(rd1_byte), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data),
        .dec_en(dec_en), .cnt_zero(cnt_zero),
        .mul_en(mul_en), .mul_prod(mul_prod)
    );

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        wr_en = 1'b0; dec_en = 1'b0; mul_en = 1'b0;
    endtask

    task automatic put(logic [2:0] sel, logic bm, logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_byte = bm; wr_data = d;
        step();
    endtask

    task automatic peek(logic [2:0] sel, logic bm, output logic [15:0] d);
        rd0_sel = sel; rd0_byte = bm;
        #1;
        d = rd0_data;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int i = 0; i < 4; i++) begin
            peek(3'(i), 1'b0, v);
            check("R1 reset value", v, 16'h0000);
        end
    endtask

    task automatic t_word();
        logic [15:0] v;
        put(3'd0, 1'b0, 16'h1234);
        put(3'd1, 1'b0, 16'h5678);
        put(3'd2, 1'b0, 16'h9ABC);
        put(3'd3, 1'b0, 16'hDEF0);
        peek(3'd3, 1'b0, v);
        check("R2 word read reg3", v, 16'hDEF0);
        peek(3'd5, 1'b0, v);
        check("R2 word sel[2] ignored", v, 16'h5678);
        rd0_sel = 3'd0; rd0_byte = 1'b0; rd1_sel = 3'd2; rd1_byte = 1'b0;
        #1;
        check("R5 port0", rd0_data, 16'h1234);
        check("R5 port1", rd1_data, 16'h9ABC);
    endtask

    task automatic t_byte();
        logic [15:0] v;
        peek(3'd0, 1'b1, v);
        check("R3 low byte", v, 16'h0034);
        peek(3'd4, 1'b1, v);
        check("R3 high byte", v, 16'h0012);
        put(3'd4, 1'b1, 16'h00AB);
        peek(3'd0, 1'b0, v);
        check("R4 high write merge", v, 16'hAB34);
        put(3'd1, 1'b1, 16'hFFCD);
        peek(3'd1, 1'b0, v);
        check("R4 low write merge", v, 16'h56CD);
    endtask

    task automatic t_rdw();
        logic [15:0] v;
        rd0_sel = 3'd3; rd0_byte = 1'b0;
        wr_en = 1'b1; wr_sel = 3'd3; wr_byte = 1'b0; wr_data = 16'h1111;
        #1;
        check("R6 old value same cycle", rd0_data, 16'hDEF0);
        step();
        peek(3'd3, 1'b0, v);
        check("R6 new value next cycle", v, 16'h1111);
    endtask

    task automatic t_dec();
        logic [15:0] v;
        put(3'd2, 1'b0, 16'h0002);
        dec_en = 1'b1;
        #1;
        check("R8 flag low at 2", {15'b0, cnt_zero}, 16'h0000);
        step();
        peek(3'd2, 1'b0, v);
        check("R7 decrement", v, 16'h0001);
        dec_en = 1'b1;
        #1;
        check("R8 flag high at 1", {15'b0, cnt_zero}, 16'h0001);
        step();
        check("R8 flag idle", {15'b0, cnt_zero}, 16'h0000);
        peek(3'd2, 1'b0, v);
        check("R7 reach zero", v, 16'h0000);
        dec_en = 1'b1;
        step();
        peek(3'd2, 1'b0, v);
        check("R7 wrap", v, 16'hFFFF);
    endtask

    task automatic t_dec_conflict();
        logic [15:0] v;
        put(3'd2, 1'b0, 16'h0010);
        dec_en = 1'b1;
        put(3'd2, 1'b0, 16'h0500);
        peek(3'd2, 1'b0, v);
        check("R9 word write wins", v, 16'h0500);
        dec_en = 1'b1;
        put(3'd6, 1'b1, 16'h0077);
        peek(3'd2, 1'b0, v);
        check("R9 byte write wins no decrement", v, 16'h7700);
    endtask

    task automatic t_mul();
        logic [15:0] v;
        mul_en = 1'b1; mul_prod = 32'h89AB_CDEF;
        step();
        peek(3'd3, 1'b0, v);
        check("R10 high word to data", v, 16'h89AB);
        peek(3'd0, 1'b0, v);
        check("R10 low word to acc", v, 16'hCDEF);
        mul_en = 1'b1; mul_prod = 32'h1111_2222;
        put(3'd0, 1'b0, 16'h5555);
        peek(3'd0, 1'b0, v);
        check("R11 write wins on acc", v, 16'h5555);
        peek(3'd3, 1'b0, v);
        check("R11 data still loads", v, 16'h1111);
    endtask

    task automatic t_both();
        logic [15:0] v;
        put(3'd2, 1'b0, 16'h0003);
        dec_en = 1'b1; mul_en = 1'b1; mul_prod = 32'hAAAA_BBBB;
        step();
        peek(3'd2, 1'b0, v);
        check("R12 counter", v, 16'h0002);
        peek(3'd3, 1'b0, v);
        check("R12 data", v, 16'hAAAA);
        peek(3'd0, 1'b0, v);
        check("R12 acc", v, 16'hBBBB);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_word();
        t_byte();
        t_rdw();
        t_dec();
        t_dec_conflict();
        t_mul();
        t_both();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule